// File: doc/BRIEF.md
# Program Flow Sequencer

This block holds the program counter of a small 16-bit processor and computes its next value every time the decoder presents an instruction. The decoder supplies the opcode together with three candidate addresses: the value of the selected register, the 16-bit immediate field, and the address of the following instruction. The block also takes the four condition flags. From these it chooses the next PC for unconditional jumps, flag-conditioned jumps, subroutine calls and returns. Any other opcode simply advances the PC.

Calls and returns need a stack memory transfer, and that transfer is carried out by a separate stack sequencer. For a call, the block asks for the link address to be pushed. For a return, it asks for a value to be popped. In both cases it holds the PC until the stack sequencer reports completion. A halt opcode clears the run bit. After that the PC and run bit stay frozen until reset.

Top module: `flow_seq`

## Requirements
- R1: After reset `pc` is 0000h, `run` is 1, and `push_req`, `pop_req` and `busy` are 0.
- R2: An accepted opcode 41h loads `pc` with `reg_val`, and 42h loads it with `imm_val`, on the clock edge that accepts it. An instruction is accepted on an edge where `instr_valid`=1, `run`=1 and `busy`=0.
- R3: Register-target conditional jumps load `pc` with `reg_val` when their flag is set: 45h tests Z=`flags[0]`, 49h tests C=`flags[1]`, 4Dh tests N=`flags[2]`, 46h tests O=`flags[3]`.
- R4: Immediate-target conditional jumps load `pc` with `imm_val` when their flag is set: 4Eh tests Z, 52h tests C, 56h tests N, 5Ah tests O. The flag bits are the same as in R3.
- R5: A conditional jump whose tested flag is clear loads `pc` with `seq_pc`.
- R6: An accepted call (51h with a register target, 5Eh with an immediate target) raises `push_req` and `busy` and presents the accepted `seq_pc` on `push_data`. `pc` holds until an edge with `stk_done`=1. On that edge `pc` takes the target latched when the call was accepted, and `push_req` falls.
- R7: An accepted 50h raises `pop_req` and `busy`, and `pc` holds. On the edge where `stk_done`=1, `pc` takes `pop_data` and `pop_req` falls.
- R8: An accepted 04h clears `run` and leaves `pc` unchanged. While `run` is 0, `pc` and `run` do not change on any input, until reset.
- R9: NOP (00h) and every opcode not listed in R2 to R8 load `pc` with `seq_pc`.
- R10: `pc` holds when `instr_valid` is 0. `instr_valid` is ignored while `busy` is 1.
- R11: `stk_done` has no effect while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Decoded instruction present this cycle |
| opcode | input | 8 | Decoded opcode |
| reg_val | input | 16 | Selected register value (register target) |
| imm_val | input | 16 | Immediate target address |
| seq_pc | input | 16 | Address of the next sequential instruction |
| flags | input | 4 | {O,N,C,Z} condition flags |
| pop_data | input | 16 | Return address delivered by the stack sequencer |
| stk_done | input | 1 | Stack transfer complete |
| pc | output | 16 | Program counter |
| run | output | 1 | Run bit |
| busy | output | 1 | Waiting for a stack transfer |
| push_req | output | 1 | Request to push `push_data` |
| push_data | output | 16 | Link address to push |
| pop_req | output | 1 | Request to pop a return address |

## Verification
The hardest situations to reach are a new instruction arriving in the middle of a call's stall, and a completion pulse arriving while the block is idle. In either case a wrong design would quietly redirect the PC. The sweep covers every opcode under all sixteen flag patterns. During each call's stall cycle it presents a competing valid jump, and it checks that the latched call target still wins once `stk_done` arrives. Each halt is followed by a jump attempt and then a reset, so the sweep continues from a known PC.

// File: rtl/flow_seq.sv
module flow_seq #(
  parameter int W = 16,
  parameter logic [W-1:0] RESET_PC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_valid,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] imm_val,
  input  logic [W-1:0] seq_pc,
  input  logic [3:0]   flags,
  input  logic [W-1:0] pop_data,
  input  logic         stk_done,
  output logic [W-1:0] pc,
  output logic         run,
  output logic         busy,
  output logic         push_req,
  output logic [W-1:0] push_data,
  output logic         pop_req
);

  typedef enum logic [1:0] {IDLE, PUSHW, POPW} st_t;
  st_t st;

  logic [W-1:0] tgt, call_tgt, link;
  logic take, is_call, is_ret, is_halt;
  logic accept;

  assign accept = run && instr_valid && (st == IDLE);

  always_comb begin
    tgt = seq_pc;
    take = 1'b0;
    is_call = 1'b0;
    is_ret = 1'b0;
    is_halt = 1'b0;
    case (opcode)
      8'h41: begin tgt = reg_val; take = 1'b1; end
      8'h42: begin tgt = imm_val; take = 1'b1; end
      8'h45: begin tgt = reg_val; take = flags[0]; end
      8'h49: begin tgt = reg_val; take = flags[1]; end
      8'h4D: begin tgt = reg_val; take = flags[2]; end
      8'h46: begin tgt = reg_val; take = flags[3]; end
      8'h4E: begin tgt = imm_val; take = flags[0]; end
      8'h52: begin tgt = imm_val; take = flags[1]; end
      8'h56: begin tgt = imm_val; take = flags[2]; end
      8'h5A: begin tgt = imm_val; take = flags[3]; end
      8'h51: begin tgt = reg_val; is_call = 1'b1; end
      8'h5E: begin tgt = imm_val; is_call = 1'b1; end
      8'h50: is_ret = 1'b1;
      8'h04: is_halt = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC;
      run <= 1'b1;
      st <= IDLE;
      call_tgt <= '0;
      link <= '0;
    end else begin
      case (st)
        IDLE: if (accept) begin
          if (is_halt) run <= 1'b0;
          else if (is_call) begin
            st <= PUSHW;
            call_tgt <= tgt;
            link <= seq_pc;
          end else if (is_ret) st <= POPW;
          else pc <= take ? tgt : seq_pc;
        end
        PUSHW: if (stk_done) begin
          pc <= call_tgt;
          st <= IDLE;
        end
        POPW: if (stk_done) begin
          pc <= pop_data;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign push_req  = (st == PUSHW);
  assign pop_req   = (st == POPW);
  assign busy      = (st != IDLE);
  assign push_data = link;

  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!run && $stable(pc)));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stk_done) |=> (busy && $stable(pc)));

  a_r6_link_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !stk_done) |=> (push_req && $stable(push_data)));

  a_r7_ret_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && stk_done) |=> (!pop_req && pc == $past(pop_data)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !instr_valid) |=> ($stable(pc) && !busy));

  a_r11_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_req, pop_req}));

endmodule

// File: tb/sim_flow_seq.sv
module sim_flow_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, stk_done = 1'b0;
  logic [7:0] opcode = '0;
  logic [15:0] reg_val = '0, imm_val = '0, seq_pc = '0, pop_data = '0;
  logic [3:0] flags = '0;
  logic [15:0] pc, push_data;
  logic run, busy, push_req, pop_req;
  int n_chk = 0, n_err = 0;

  flow_seq u0 (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .reg_val(reg_val), .imm_val(imm_val), .seq_pc(seq_pc), .flags(flags),
    .pop_data(pop_data), .stk_done(stk_done), .pc(pc), .run(run), .busy(busy),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [7:0] op, input logic [3:0] f,
      input logic [15:0] r, input logic [15:0] i, input logic [15:0] s);
    case (op)
      8'h41: return r;
      8'h42: return i;
      8'h45: return f[0] ? r : s;
      8'h49: return f[1] ? r : s;
      8'h4D: return f[2] ? r : s;
      8'h46: return f[3] ? r : s;
      8'h4E: return f[0] ? i : s;
      8'h52: return f[1] ? i : s;
      8'h56: return f[2] ? i : s;
      8'h5A: return f[3] ? i : s;
      default: return s;
    endcase
  endfunction

  function automatic string tag(input logic [7:0] op);
    case (op)
      8'h41, 8'h42: return "R2";
      8'h45, 8'h49, 8'h4D, 8'h46: return "R3/R5";
      8'h4E, 8'h52, 8'h56, 8'h5A: return "R4/R5";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] pexp, rv, iv, sv, tg;
    @(negedge clk); @(negedge clk);
    chk("R1 pc", pc, 16'h0000);
    chk("R1 run", {15'd0, run}, 16'd1);
    chk("R1 req", {13'd0, busy, push_req, pop_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pexp = 16'h0000;
    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 16; f++) begin
        rv = 16'h1000 ^ {4'h0, op[7:0], f[3:0]};
        iv = 16'h8001 ^ {op[7:0], f[3:0], 4'h5};
        sv = 16'h2000 + {4'h0, op[7:0], f[3:0]};
        opcode = op[7:0]; flags = f[3:0];
        reg_val = rv; imm_val = iv; seq_pc = sv;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (op == 8'h04) begin
          chk("R8 run", {15'd0, run}, 16'd0);
          chk("R8 pc", pc, pexp);
          opcode = 8'h42; instr_valid = 1'b1;
          @(negedge clk);
          instr_valid = 1'b0;
          chk("R8 frozen pc", pc, pexp);
          chk("R8 frozen run", {15'd0, run}, 16'd0);
          rst_n = 1'b0;
          @(negedge clk);
          rst_n = 1'b1;
          chk("R1 pc after reset", pc, 16'h0000);
          chk("R1 run after reset", {15'd0, run}, 16'd1);
          pexp = 16'h0000;
        end else if (op == 8'h51 || op == 8'h5E) begin
          tg = (op == 8'h51) ? rv : iv;
          chk("R6 push_req", {15'd0, push_req}, 16'd1);
          chk("R6 push_data", push_data, sv);
          chk("R6 stall pc", pc, pexp);
          opcode = 8'h42; imm_val = 16'hDEAD; seq_pc = 16'hBEEF; instr_valid = 1'b1;
          @(negedge clk);
          instr_valid = 1'b0;
          chk("R10 busy ignores valid", pc, pexp);
          chk("R6 link held", push_data, sv);
          stk_done = 1'b1;
          @(negedge clk);
          stk_done = 1'b0;
          chk("R6 call target", pc, tg);
          chk("R6 push_req low", {15'd0, push_req}, 16'd0);
          pexp = tg;
        end else if (op == 8'h50) begin
          chk("R7 pop_req", {15'd0, pop_req}, 16'd1);
          chk("R7 stall pc", pc, pexp);
          pop_data = 16'hC000 ^ {4'h0, op[7:0], f[3:0]};
          @(negedge clk);
          chk("R7 still stalled", pc, pexp);
          stk_done = 1'b1;
          @(negedge clk);
          stk_done = 1'b0;
          chk("R7 return pc", pc, pop_data);
          chk("R7 pop_req low", {15'd0, pop_req}, 16'd0);
          pexp = pop_data;
        end else begin
          pexp = model(op[7:0], f[3:0], rv, iv, sv);
          chk(tag(op[7:0]), pc, pexp);
        end
        if (f == 15) begin
          seq_pc = 16'h7777; stk_done = 1'b1;
          @(negedge clk);
          stk_done = 1'b0;
          chk("R11 idle done ignored", pc, pexp);
          chk("R10 no valid hold", {15'd0, busy}, 16'd0);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule